// File: doc/BRIEF.md
# SRAM Framebuffer VGA Scan Generator

This block is the timing engine of a framebuffer display path. It counts pixel clocks and lines, drives the active-low horizontal and vertical sync pulses, and sends the external SRAM a read address for every framebuffer pixel. The SRAM then puts its colour byte straight onto the DAC path. By default it runs at the 25.175 MHz pixel rate with 800 clocks per line and 512 lines per frame. It shows 256 framebuffer columns per visible line, and each column is held for two clocks.

The block drives two enables. The SRAM output enable is pulled low during visible pixels. The colour-buffer enable follows it one clock later, which leaves room for the SRAM read latency, and it is forced off whenever either sync pulse is low. Colour leaving the block is forced to zero whenever the buffer enable is off. The last framebuffer column of each line is kept dark so that the image has a clean right edge.

Other logic can find the non-display time from a frame-start pulse, the current line number and a flag that is high through the 32 lines that follow the visible region. A static input selects the memory bank and a second input selects the display page.

Top module: `vga_sram_scan`

## Requirements
- R1: Every line is exactly H_TOTAL clocks long (default 800). Consecutive falling edges of `hsync_n` are always H_TOTAL clocks apart.
- R2: A frame is V_TOTAL lines (default 512). `frame_start` is high for one clock per frame, in the first clock of line 0, so consecutive pulses are H_TOTAL*V_TOTAL clocks apart.
- R3: `hsync_n` is low for HS_LEN clocks (default 70), starting at clock HS_START of the line (default 600). HS_START lies after the active video.
- R4: `vsync_n` is low for exactly two whole lines, VS_LINE and VS_LINE+1. Both lines lie inside the blank region.
- R5: `sram_addr` is {bank, page, line[LINE_BITS-1:0], column[COL_BITS-1:0]}. The bank is the MSB, the page is the next bit and the column sits in the LSBs. Column = clock-in-line / 2 for the first 2*2^COL_BITS clocks of a line and 0 after them, so each column lasts two clocks.
- R6: `sram_oe_n` is low exactly when the line is below V_ACTIVE and the clock in the line is below 2*(2^COL_BITS − 1). The last column is blanked.
- R7: `buf_oe_n` is low only in the clock after a clock with `sram_oe_n` low, and only while both syncs are high.
- R8: `rgb_out` equals `sram_data` while `buf_oe_n` is low and is zero while it is high.
- R9: `line_num` gives the current line. `vblank` is high exactly when that line is V_ACTIVE or later.
- R10: While `rst_n` is low, and in the clock right after it is released, the outputs are idle: both syncs high, both enables high, address 0, `rgb_out` 0, `frame_start` 0, `line_num` 0, `vblank` 0. Scanning then begins at line 0, clock 0.
- R11: Outputs are registered one clock behind the counters. The output seen after the k-th clock edge following reset release describes position k−1 of the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Static bank select, placed in the address MSB |
| page_sel | input | 1 | Display page select |
| sram_data | input | DATA_W | Colour byte read from the SRAM |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| sram_addr | output | COL_BITS+LINE_BITS+2 | SRAM read address |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| buf_oe_n | output | 1 | Colour-buffer enable, active low |
| rgb_out | output | DATA_W | Gated colour towards the DAC |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| line_num | output | LINE_BITS | Current line |
| vblank | output | 1 | High during the non-visible lines |

## Verification
The bench targets four corner cases. The first is the last framebuffer column: a design that forgot to blank it would leave `sram_oe_n` low for two more clocks per line. The second is the one-clock lag between the SRAM enable and the buffer enable: a design that skipped it would put unsettled data on the DAC at the first pixel. The third is the line and frame wraps: an off-by-one count would change the spacing between sync edges and show up as a jagged picture. The fourth is a reset in the middle of a frame: a design that did not reset cleanly would resume from a stale position instead of line 0. Bank and page are set to each combination while the bench checks the full address on every clock.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

   // registered per-position status, one flop each
   typedef struct packed {
      logic hsync_n;
      logic vsync_n;
      logic pix_vis;
      logic vblank;
      logic frame_start;
   } scan_flags_t;

   localparam scan_flags_t FLAGS_IDLE = '{
      hsync_n:     1'b1,
      vsync_n:     1'b1,
      pix_vis:     1'b0,
      vblank:      1'b0,
      frame_start: 1'b0
   };

endpackage

// File: rtl/vga_scan_counter.sv
module vga_scan_counter #(
   parameter int H_TOTAL = 800,
   parameter int V_TOTAL = 512,
   parameter int H_W     = 10,
   parameter int V_W     = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [H_W-1:0] h_cnt,
   output logic [V_W-1:0] v_cnt
);

   localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
   localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (h_cnt == H_LAST) begin
         h_cnt <= '0;
         v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
      end else begin
         h_cnt <= h_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/vga_scan_timing.sv
module vga_scan_timing
   import vga_scan_pkg::*;
#(
   parameter int H_W      = 10,
   parameter int V_W      = 9,
   parameter int COL_BITS = 8,
   parameter int HS_START = 600,
   parameter int HS_LEN   = 70,
   parameter int V_ACTIVE = 480,
   parameter int VS_LINE  = 490
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [H_W-1:0] h_cnt,
   input  logic [V_W-1:0] v_cnt,
   output scan_flags_t    flags_q,
   output logic [V_W-1:0] line_q
);

   localparam int COLS = 1 << COL_BITS;
   localparam logic [H_W-1:0] HS_BEG  = H_W'(HS_START);
   localparam logic [H_W-1:0] HS_END  = H_W'(HS_START + HS_LEN);
   localparam logic [H_W-1:0] VIS_END = H_W'(2 * (COLS - 1));
   localparam logic [V_W-1:0] VACT    = V_W'(V_ACTIVE);
   localparam logic [V_W-1:0] VS_A    = V_W'(VS_LINE);
   localparam logic [V_W-1:0] VS_B    = V_W'(VS_LINE + 1);

   scan_flags_t nxt;

   always_comb begin
      nxt.hsync_n     = !((h_cnt >= HS_BEG) && (h_cnt < HS_END));
      nxt.vsync_n     = !((v_cnt == VS_A) || (v_cnt == VS_B));
      nxt.pix_vis     = (h_cnt < VIS_END) && (v_cnt < VACT);
      nxt.vblank      = (v_cnt >= VACT);
      nxt.frame_start = (h_cnt == '0) && (v_cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= FLAGS_IDLE;
         line_q  <= '0;
      end else begin
         flags_q <= nxt;
         line_q  <= v_cnt;
      end
   end

endmodule

// File: rtl/vga_scan_addr.sv
module vga_scan_addr #(
   parameter int H_W      = 10,
   parameter int V_W      = 9,
   parameter int COL_BITS = 8,
   parameter int ADDR_W   = COL_BITS + V_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel,
   input  logic              page_sel,
   input  logic [H_W-1:0]    h_cnt,
   input  logic [V_W-1:0]    v_cnt,
   output logic [ADDR_W-1:0] addr_q
);

   localparam logic [H_W-1:0] ACT_END = H_W'(2 * (1 << COL_BITS));

   logic [COL_BITS-1:0] col;
   logic [H_W-1:0]      half;

   // two clocks per framebuffer column
   assign half = h_cnt >> 1;

   always_comb begin
      col = (h_cnt < ACT_END) ? half[COL_BITS-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= {bank_sel, page_sel, v_cnt, col};
   end

endmodule

// File: rtl/vga_scan_colour.sv
module vga_scan_colour #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vis_q,
   input  logic              hsync_n,
   input  logic              vsync_n,
   input  logic [DATA_W-1:0] sram_data,
   output logic              buf_oe_n,
   output logic [DATA_W-1:0] rgb_out
);

   logic buf_en_q;

   // one clock behind the SRAM enable to cover read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_en_q <= 1'b0;
      else        buf_en_q <= pix_vis_q;
   end

   assign buf_oe_n = !buf_en_q || !hsync_n || !vsync_n;

   for (genvar b = 0; b < DATA_W; b++) begin : g_gate
      assign rgb_out[b] = sram_data[b] & !buf_oe_n;
   end

endmodule

// File: rtl/vga_sram_scan.sv
module vga_sram_scan
   import vga_scan_pkg::*;
#(
   parameter int H_TOTAL   = 800,
   parameter int HS_START  = 600,
   parameter int HS_LEN    = 70,
   parameter int COL_BITS  = 8,
   parameter int LINE_BITS = 9,
   parameter int V_TOTAL   = 512,
   parameter int V_ACTIVE  = 480,
   parameter int VS_LINE   = 490,
   parameter int DATA_W    = 8,
   localparam int ADDR_W   = COL_BITS + LINE_BITS + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bank_sel,
   input  logic                 page_sel,
   input  logic [DATA_W-1:0]    sram_data,
   output logic                 hsync_n,
   output logic                 vsync_n,
   output logic [ADDR_W-1:0]    sram_addr,
   output logic                 sram_oe_n,
   output logic                 buf_oe_n,
   output logic [DATA_W-1:0]    rgb_out,
   output logic                 frame_start,
   output logic [LINE_BITS-1:0] line_num,
   output logic                 vblank
);

   localparam int H_W  = $clog2(H_TOTAL + 1);
   localparam int V_W  = LINE_BITS;
   localparam int COLS = 1 << COL_BITS;

   if (H_W <= COL_BITS) begin : g_bad_hw
      $error("line counter narrower than column field");
   end
   if (HS_START < 2 * COLS || HS_LEN < 1 || HS_START + HS_LEN > H_TOTAL) begin : g_bad_hs
      $error("horizontal sync must lie after active video and inside the line");
   end
   if (V_ACTIVE >= V_TOTAL || V_TOTAL > (1 << LINE_BITS)) begin : g_bad_v
      $error("vertical totals do not fit the line field");
   end
   if (VS_LINE < V_ACTIVE || VS_LINE + 2 > V_TOTAL) begin : g_bad_vs
      $error("vertical sync must lie inside the blank lines");
   end

   logic [H_W-1:0] h_cnt;
   logic [V_W-1:0] v_cnt;
   scan_flags_t    flags_q;

   vga_scan_counter #(
      .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_W(H_W), .V_W(V_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt)
   );

   vga_scan_timing #(
      .H_W(H_W), .V_W(V_W), .COL_BITS(COL_BITS), .HS_START(HS_START),
      .HS_LEN(HS_LEN), .V_ACTIVE(V_ACTIVE), .VS_LINE(VS_LINE)
   ) u_tim (
      .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .flags_q(flags_q), .line_q(line_num)
   );

   vga_scan_addr #(
      .H_W(H_W), .V_W(V_W), .COL_BITS(COL_BITS), .ADDR_W(ADDR_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .page_sel(page_sel),
      .h_cnt(h_cnt), .v_cnt(v_cnt), .addr_q(sram_addr)
   );

   assign hsync_n     = flags_q.hsync_n;
   assign vsync_n     = flags_q.vsync_n;
   assign sram_oe_n   = !flags_q.pix_vis;
   assign frame_start = flags_q.frame_start;
   assign vblank      = flags_q.vblank;

   vga_scan_colour #(.DATA_W(DATA_W)) u_col (
      .clk(clk), .rst_n(rst_n), .pix_vis_q(flags_q.pix_vis),
      .hsync_n(flags_q.hsync_n), .vsync_n(flags_q.vsync_n),
      .sram_data(sram_data), .buf_oe_n(buf_oe_n), .rgb_out(rgb_out)
   );

endmodule

// File: rtl/vga_sram_scan_chk.sv
module vga_sram_scan_chk #(
   parameter int H_TOTAL   = 800,
   parameter int DATA_W    = 8,
   parameter int LINE_BITS = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 hsync_n,
   input logic                 vsync_n,
   input logic                 sram_oe_n,
   input logic                 buf_oe_n,
   input logic [DATA_W-1:0]    rgb_out,
   input logic                 frame_start,
   input logic [LINE_BITS-1:0] line_num,
   input logic                 vblank
);

   logic        hs_prev;
   logic        seen_fall;
   logic [15:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev   <= 1'b1;
         seen_fall <= 1'b0;
         gap       <= '0;
      end else begin
         hs_prev <= hsync_n;
         if (hs_prev && !hsync_n) begin
            seen_fall <= 1'b1;
            gap       <= 16'd1;
         end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
         end
      end
   end

   assert_line_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_prev && !hsync_n && seen_fall) |-> (gap == 16'(H_TOTAL)));

   assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_frame_line0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (line_num == '0 && !vblank));

   assert_vsync_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> vblank);

   assert_oe_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !vblank);

   assert_buf_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync_n || !vsync_n) |-> buf_oe_n);

   assert_buf_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_oe_n |-> $past(!sram_oe_n));

   assert_rgb_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_oe_n |-> (rgb_out == '0));

endmodule

bind vga_sram_scan vga_sram_scan_chk #(
   .H_TOTAL(H_TOTAL), .DATA_W(DATA_W), .LINE_BITS(LINE_BITS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .sram_oe_n(sram_oe_n), .buf_oe_n(buf_oe_n), .rgb_out(rgb_out),
   .frame_start(frame_start), .line_num(line_num), .vblank(vblank)
);

// File: tb/vga_sram_scan_tb_top.sv
module vga_sram_scan_tb_top;

   localparam int HT   = 24;
   localparam int HSS  = 18;
   localparam int HSL  = 3;
   localparam int CB   = 3;
   localparam int LB   = 3;
   localparam int VT   = 8;
   localparam int VA   = 6;
   localparam int VSL  = 6;
   localparam int DW   = 8;
   localparam int AW   = CB + LB + 2;
   localparam int COLS = 1 << CB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bank_sel = 1'b0;
   logic          page_sel = 1'b0;
   logic [DW-1:0] sram_data = '0;
   logic          hsync_n, vsync_n, sram_oe_n, buf_oe_n, frame_start, vblank;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] rgb_out;
   logic [LB-1:0] line_num;

   int k = 0;
   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) k <= 0;
      else        k <= k + 1;
   end

   vga_sram_scan #(
      .H_TOTAL(HT), .HS_START(HSS), .HS_LEN(HSL), .COL_BITS(CB),
      .LINE_BITS(LB), .V_TOTAL(VT), .V_ACTIVE(VA), .VS_LINE(VSL), .DATA_W(DW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .page_sel(page_sel),
      .sram_data(sram_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .sram_addr(sram_addr), .sram_oe_n(sram_oe_n), .buf_oe_n(buf_oe_n),
      .rgb_out(rgb_out), .frame_start(frame_start), .line_num(line_num),
      .vblank(vblank)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
      end
   endtask

   function automatic int hpos(int p); return p % HT; endfunction
   function automatic int vpos(int p); return (p / HT) % VT; endfunction
   function automatic bit vis_at(int p);
      if (p < 0) return 1'b0;
      return (hpos(p) < 2 * (COLS - 1)) && (vpos(p) < VA);
   endfunction

   // R10: idle outputs during and right after reset
   task automatic test_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sram_data = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R10 hsync", hsync_n, 1);
      chk("R10 vsync", vsync_n, 1);
      chk("R10 sram_oe", sram_oe_n, 1);
      chk("R10 buf_oe", buf_oe_n, 1);
      chk("R10 addr", sram_addr, 0);
      chk("R10 rgb", rgb_out, 0);
      chk("R10 frame_start", frame_start, 0);
      chk("R10 line", line_num, 0);
      chk("R10 vblank", vblank, 0);
      rst_n = 1'b1;
   endtask

   // R3 R4 R5 R6 R7 R8 R9 R11: every output, every clock
   task automatic test_scan(input bit bank, input bit page, input int cycles, input int seed);
      bank_sel = bank;
      page_sel = page;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         sram_data = DW'(k * 37 + seed);
         #1;
         if (k >= 1) begin
            int p  = k - 1;
            int h  = hpos(p);
            int v  = vpos(p);
            int hs = ((h >= HSS) && (h < HSS + HSL)) ? 0 : 1;
            int vs = ((v == VSL) || (v == VSL + 1)) ? 0 : 1;
            int col = (h < 2 * COLS) ? h / 2 : 0;
            int ea = (int'(bank) << (AW - 1)) | (int'(page) << (AW - 2)) | (v << CB) | col;
            int eb = (vis_at(p - 1) && hs == 1 && vs == 1) ? 0 : 1;
            chk("R3 hsync", hsync_n, hs);
            chk("R4 vsync", vsync_n, vs);
            chk("R5 addr", sram_addr, ea);
            chk("R6 sram_oe", sram_oe_n, vis_at(p) ? 0 : 1);
            chk("R7 buf_oe", buf_oe_n, eb);
            chk("R8 rgb", rgb_out, eb == 0 ? int'(sram_data) : 0);
            chk("R2 frame_start", frame_start, (h == 0 && v == 0) ? 1 : 0);
            chk("R9 line", line_num, v);
            chk("R9 vblank", vblank, v >= VA ? 1 : 0);
         end
      end
   endtask

   // R1 R2 R3 R4: spacing and widths measured at the ports
   task automatic test_periods();
      int last_hf = -1, last_fs = -1, last_vf = -1, hs_lo = 0, vs_lo = 0;
      bit prev_hs = 1'b1, prev_vs = 1'b1;
      int n_hf = 0, n_fs = 0;
      for (int t = 0; t < 2 * HT * VT + 5; t++) begin
         @(negedge clk);
         if (prev_hs && !hsync_n) begin
            if (last_hf >= 0) chk("R1 line period", t - last_hf, HT);
            last_hf = t;
            n_hf++;
         end
         if (!prev_hs && hsync_n && last_hf >= 0) chk("R3 hsync width", hs_lo, HSL);
         hs_lo = hsync_n ? 0 : hs_lo + 1;
         if (prev_vs && !vsync_n) last_vf = t;
         if (!prev_vs && vsync_n && last_vf >= 0) chk("R4 vsync width", vs_lo, 2 * HT);
         vs_lo = vsync_n ? 0 : vs_lo + 1;
         if (frame_start) begin
            if (last_fs >= 0) chk("R2 frame period", t - last_fs, HT * VT);
            last_fs = t;
            n_fs++;
         end
         prev_hs = hsync_n;
         prev_vs = vsync_n;
      end
      chk("R1 line count", n_hf >= 2 * VT ? 1 : 0, 1);
      chk("R2 frame count", n_fs, 2);
   endtask

   initial begin
      test_reset();
      test_scan(1'b0, 1'b0, HT * VT + 10, 5);
      test_periods();
      test_scan(1'b1, 1'b1, HT * VT, 200);
      test_reset();
      test_scan(1'b1, 1'b0, HT * VT + HT, 91);
      test_scan(1'b0, 1'b1, HT * 3, 17);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule